// File: doc/BRIEF.md
# Two-Level Page Walker with Accessed/Dirty Update

This block resolves a translation miss for a 4 KB page. It reads the page-directory entry, then the page-table entry, over a simple processor bus. The bus has an address strobe, a ready return and a lock line. It then hands the translated frame to the TLB and issues the read of the missed location as a cache-line fill.

Each entry is first tested with a plain read. If the tracking bits the access needs are already 1, the walker moves on. If not, it performs a locked read followed by a write of the same word with the bits set. The lock is raised together with the address strobe of that read and dropped once the write has completed. A write access also marks the page-table entry dirty. An entry whose present bit is 0 ends the walk with a fault and no write.

Top module: `pt_walker`

## Requirements
- R1: A miss request is taken only while `miss_ready_o` is 1, which holds exactly while the walker is idle. A request raised during a walk has no effect on the bus traffic or on the TLB output of that walk.
- R2: The first bus cycle of a walk is an unlocked read at `dir_base_i + 4 * lin[31:22]`, with the base and linear address captured when the request is accepted.
- R3: The page-table entry is read at `{pde[31:12], 12'h000} + 4 * lin[21:12]`.
- R4: Each entry gets one unlocked test read. If all tested bits are 1, no further bus cycle addresses that entry.
- R5: If a tested bit is 0, the next two cycles are a locked read and then a locked write to the same address. The write data is the locked read data with the tested bits set.
- R6: `bus_lock_o` is 1 from the strobe of the locked read through the ready of the locked write, and 0 in the cycle after that ready.
- R7: Bit positions are present = bit 0, accessed = bit 5 and dirty = bit 6. The directory entry is tested for accessed only. The table entry is tested for accessed on a read access and for accessed plus dirty on a write access.
- R8: A present bit of 0 in a test read or a locked read ends the walk. It gives a one-cycle `walk_fault_o`, performs no write and no fill, and makes no TLB load.
- R9: On success, `tlb_load_o` pulses for one cycle, in the same cycle as the fill strobe. `tlb_vpn_o` = lin[31:12] and `tlb_pfn_o` = final table entry [31:12].
- R10: The fill read addresses `{pfn, lin[11:0]}` with `bus_fill_o` = 1. It completes after LINE_BEATS ready beats, and the walker is idle in the cycle after the last beat.
- R11: Address, write and lock outputs stay stable from a strobe until the ready that ends that bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_base_i | input | 32 | Directory base address |
| miss_valid_i | input | 1 | Miss request |
| miss_lin_i | input | 32 | Linear address of the miss |
| miss_write_i | input | 1 | Miss is a write access |
| miss_ready_o | output | 1 | Idle, request accepted |
| bus_ads_o | output | 1 | Address strobe, one cycle per bus cycle |
| bus_addr_o | output | 32 | Bus address |
| bus_wr_o | output | 1 | Bus cycle is a write |
| bus_lock_o | output | 1 | Locked pair in progress |
| bus_fill_o | output | 1 | Bus cycle is the line fill |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with ready |
| bus_brdy_i | input | 1 | Ready, ends a bus cycle or beat |
| tlb_load_o | output | 1 | TLB load pulse |
| tlb_vpn_o | output | 20 | Linear page number |
| tlb_pfn_o | output | 20 | Physical frame number |
| walk_fault_o | output | 1 | Not-present fault pulse |

## Verification
A strobe follows one cycle after acceptance, and one cycle after the ready that closes the previous bus cycle. The TLB load coincides with the fill strobe. A fault and the return to idle both appear one cycle after the ready of the failing read. The bench drives and samples on the falling edge, logs every strobe with its address, write, lock and fill flags, and compares the log and the bus memory with the expected sequence only after ready returns. Lock release and address hold are checked at the falling edge right after each ready, where the design's registered outputs have already settled.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  localparam int unsigned ENT_W    = 32;
  localparam int unsigned PG_SHIFT = 12;
  localparam int unsigned IDX_W    = 10;
  localparam int unsigned FRAME_W  = ENT_W - PG_SHIFT;
  localparam int unsigned P_BIT    = 0;
  localparam int unsigned A_BIT    = 5;
  localparam int unsigned D_BIT    = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_CHK,
    ST_DIR_LRD,
    ST_DIR_LWR,
    ST_TBL_CHK,
    ST_TBL_LRD,
    ST_TBL_LWR,
    ST_FILL
  } walk_st_e;
endpackage

// File: rtl/pw_addr_gen.sv
`timescale 1ns/1ps
module pw_addr_gen
  import pw_pkg::*;
(
  input  walk_st_e             st_i,
  input  logic [ENT_W-1:0]     base_i,
  input  logic [ENT_W-1:0]     lin_i,
  input  logic [FRAME_W-1:0]   frame_i,
  output logic [ENT_W-1:0]     addr_o
);
  localparam int unsigned PAD_W = ENT_W - IDX_W - 2;

  logic [ENT_W-1:0] dir_off;
  logic [ENT_W-1:0] tbl_addr;

  assign dir_off  = {{PAD_W{1'b0}}, lin_i[ENT_W-1 -: IDX_W], 2'b00};
  assign tbl_addr = {frame_i, lin_i[PG_SHIFT +: IDX_W], 2'b00};

  always_comb begin
    unique case (st_i)
      ST_DIR_CHK, ST_DIR_LRD, ST_DIR_LWR: addr_o = base_i + dir_off;
      ST_TBL_CHK, ST_TBL_LRD, ST_TBL_LWR: addr_o = tbl_addr;
      ST_FILL:                            addr_o = {frame_i, lin_i[PG_SHIFT-1:0]};
      default:                            addr_o = '0;
    endcase
  end
endmodule

// File: rtl/pw_beat_ctr.sv
`timescale 1ns/1ps
module pw_beat_ctr #(
  parameter int unsigned BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic last_o
);
  generate
    if (BEATS <= 1) begin : g_single
      assign last_o = step_i;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(BEATS);
      localparam logic [CNT_W-1:0] LAST_V = CNT_W'(BEATS - 1);
      logic [CNT_W-1:0] cnt_q;

      assign last_o = step_i && (cnt_q == LAST_V);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (last_o) cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + 1'b1;
      end

      AST_BEAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST_V); // R10
    end
  endgenerate
endmodule

// File: rtl/pw_seq.sv
`timescale 1ns/1ps
module pw_seq
  import pw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 miss_valid_i,
  input  logic                 miss_write_i,
  output logic                 ready_o,
  output logic                 accept_o,
  input  logic [ENT_W-1:0]     rdata_i,
  input  logic                 brdy_i,
  input  logic                 fill_last_i,
  output walk_st_e             st_o,
  output logic                 pend_o,
  output logic                 ads_o,
  output logic                 wr_o,
  output logic                 lock_o,
  output logic                 fill_o,
  output logic [ENT_W-1:0]     wdata_o,
  output logic [FRAME_W-1:0]   frame_o,
  output logic                 load_o,
  output logic                 fault_o
);
  walk_st_e st_q, st_d, phase_nxt;
  logic issued_q, write_q, fault_q, fault_d;
  logic [ENT_W-1:0] ent_q, mask;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic in_tbl, in_chk, in_lrd, in_lwr, done, present, bits_ok;

  assign in_tbl  = st_q inside {ST_TBL_CHK, ST_TBL_LRD, ST_TBL_LWR};
  assign in_chk  = st_q inside {ST_DIR_CHK, ST_TBL_CHK};
  assign in_lrd  = st_q inside {ST_DIR_LRD, ST_TBL_LRD};
  assign in_lwr  = st_q inside {ST_DIR_LWR, ST_TBL_LWR};
  assign done    = issued_q && brdy_i;
  assign present = rdata_i[P_BIT];

  always_comb begin
    mask        = '0;
    mask[A_BIT] = 1'b1;
    mask[D_BIT] = in_tbl && write_q;  // dirty only on table entry, write access
  end

  assign bits_ok   = (rdata_i & mask) == mask;
  assign phase_nxt = in_tbl ? ST_FILL : ST_TBL_CHK;

  assign ready_o  = st_q == ST_IDLE;
  assign accept_o = ready_o && miss_valid_i;
  assign ads_o    = !ready_o && !issued_q;
  assign wr_o     = in_lwr;
  assign lock_o   = in_lrd || in_lwr;
  assign fill_o   = st_q == ST_FILL;
  assign wdata_o  = ent_q | mask;
  assign frame_o  = frame_q;
  assign load_o   = fill_o && !issued_q;
  assign fault_o  = fault_q;
  assign st_o     = st_q;
  assign pend_o   = issued_q;

  always_comb begin
    st_d    = st_q;
    frame_d = frame_q;
    fault_d = 1'b0;
    if (st_q == ST_IDLE) begin
      if (accept_o) st_d = ST_DIR_CHK;
    end else if (done) begin
      if (in_chk) begin
        if (!present) begin
          st_d    = ST_IDLE;
          fault_d = 1'b1;
        end else if (bits_ok) begin
          st_d    = phase_nxt;
          frame_d = rdata_i[ENT_W-1:PG_SHIFT];
        end else begin
          st_d = in_tbl ? ST_TBL_LRD : ST_DIR_LRD;
        end
      end else if (in_lrd) begin
        if (!present) begin
          st_d    = ST_IDLE;
          fault_d = 1'b1;
        end else begin
          st_d = in_tbl ? ST_TBL_LWR : ST_DIR_LWR;
        end
      end else if (in_lwr) begin
        st_d    = phase_nxt;
        frame_d = ent_q[ENT_W-1:PG_SHIFT];
      end else if (fill_last_i) begin
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      write_q  <= 1'b0;
      fault_q  <= 1'b0;
      ent_q    <= '0;
      frame_q  <= '0;
    end else begin
      st_q     <= st_d;
      issued_q <= (st_d != st_q) ? 1'b0 : (issued_q || ads_o);
      fault_q  <= fault_d;
      frame_q  <= frame_d;
      if (accept_o)                     write_q <= miss_write_i;
      if (done && (in_chk || in_lrd))   ent_q   <= rdata_i;
    end
  end

  AST_LOCK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_lwr && done) |=> !lock_o); // R6
  AST_WRITE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_o && wr_o) |-> lock_o); // R5
  AST_LWR_AFTER_LRD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_o) |-> $past(in_lrd && done && present)); // R5
  AST_FAULT_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!load_o && !lock_o)); // R8
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R9
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pw_pkg::*;
#(
  parameter int unsigned LINE_BEATS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ENT_W-1:0]     dir_base_i,
  input  logic                 miss_valid_i,
  input  logic [ENT_W-1:0]     miss_lin_i,
  input  logic                 miss_write_i,
  output logic                 miss_ready_o,
  output logic                 bus_ads_o,
  output logic [ENT_W-1:0]     bus_addr_o,
  output logic                 bus_wr_o,
  output logic                 bus_lock_o,
  output logic                 bus_fill_o,
  output logic [ENT_W-1:0]     bus_wdata_o,
  input  logic [ENT_W-1:0]     bus_rdata_i,
  input  logic                 bus_brdy_i,
  output logic                 tlb_load_o,
  output logic [FRAME_W-1:0]   tlb_vpn_o,
  output logic [FRAME_W-1:0]   tlb_pfn_o,
  output logic                 walk_fault_o
);
  logic [ENT_W-1:0] lin_q, base_q;
  logic [FRAME_W-1:0] frame;
  logic accept, pend, fill_last;
  walk_st_e st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      lin_q  <= miss_lin_i;
      base_q <= dir_base_i;
    end
  end

  pw_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .miss_write_i (miss_write_i),
    .ready_o      (miss_ready_o),
    .accept_o     (accept),
    .rdata_i      (bus_rdata_i),
    .brdy_i       (bus_brdy_i),
    .fill_last_i  (fill_last),
    .st_o         (st),
    .pend_o       (pend),
    .ads_o        (bus_ads_o),
    .wr_o         (bus_wr_o),
    .lock_o       (bus_lock_o),
    .fill_o       (bus_fill_o),
    .wdata_o      (bus_wdata_o),
    .frame_o      (frame),
    .load_o       (tlb_load_o),
    .fault_o      (walk_fault_o)
  );

  pw_addr_gen u_addr (
    .st_i    (st),
    .base_i  (base_q),
    .lin_i   (lin_q),
    .frame_i (frame),
    .addr_o  (bus_addr_o)
  );

  pw_beat_ctr #(.BEATS(LINE_BEATS)) u_beats (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (bus_fill_o && pend && bus_brdy_i),
    .last_o (fill_last)
  );

  assign tlb_vpn_o = lin_q[ENT_W-1:PG_SHIFT];
  assign tlb_pfn_o = frame;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !bus_brdy_i) |=> ($stable(bus_addr_o) && $stable(bus_lock_o) && $stable(bus_wr_o))); // R11
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_o |-> (!bus_ads_o && !bus_lock_o && !bus_fill_o)); // R1
  AST_ADS_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_ready_o && miss_valid_i) |=> (bus_ads_o && !bus_lock_o && !bus_wr_o)); // R2
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  import pw_pkg::*;

  localparam int BEATS = 4;
  localparam logic [31:0] BASE = 32'h0000_8000;

  typedef struct packed {
    logic [31:0] lin;
    logic        wr;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [3:0]  ncyc;
    logic        flt;
    logic [31:0] pde_f;
    logic [31:0] pte_f;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{32'h1234_5678, 1'b0, 32'h0012_3021, 32'h0045_6061, 4'd3, 1'b0, 32'h0012_3021, 32'h0045_6061},
    '{32'h0040_1ABC, 1'b0, 32'h0012_3001, 32'h0045_6001, 4'd7, 1'b0, 32'h0012_3021, 32'h0045_6021},
    '{32'hFFC0_2FFF, 1'b1, 32'h0012_3021, 32'hABCD_E021, 4'd5, 1'b0, 32'h0012_3021, 32'hABCD_E061},
    '{32'h8000_0000, 1'b1, 32'h0077_7001, 32'h0045_6001, 4'd7, 1'b0, 32'h0077_7021, 32'h0045_6061},
    '{32'h1234_5678, 1'b0, 32'h0012_3020, 32'h0045_6061, 4'd1, 1'b1, 32'h0012_3020, 32'h0045_6061},
    '{32'h0000_1000, 1'b1, 32'h0012_3021, 32'h0045_6060, 4'd2, 1'b1, 32'h0012_3021, 32'h0045_6060},
    '{32'h7654_3210, 1'b0, 32'h0012_3021, 32'h0045_6041, 4'd5, 1'b0, 32'h0012_3021, 32'h0045_6061}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] dir_base_i, miss_lin_i, bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic miss_valid_i, miss_write_i, miss_ready_o, bus_ads_o, bus_wr_o, bus_lock_o;
  logic bus_fill_o, bus_brdy_i, tlb_load_o, walk_fault_o;
  logic [19:0] tlb_vpn_o, tlb_pfn_o;

  always #2 clk = ~clk;

  pt_walker #(.LINE_BEATS(BEATS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dir_base_i(dir_base_i),
    .miss_valid_i(miss_valid_i), .miss_lin_i(miss_lin_i), .miss_write_i(miss_write_i),
    .miss_ready_o(miss_ready_o), .bus_ads_o(bus_ads_o), .bus_addr_o(bus_addr_o),
    .bus_wr_o(bus_wr_o), .bus_lock_o(bus_lock_o), .bus_fill_o(bus_fill_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_brdy_i(bus_brdy_i),
    .tlb_load_o(tlb_load_o), .tlb_vpn_o(tlb_vpn_o), .tlb_pfn_o(tlb_pfn_o),
    .walk_fault_o(walk_fault_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] m_addr [2];
  logic [31:0] m_data [2];
  int n_log = 0;
  logic [31:0] log_addr [128];
  logic log_wr [128];
  logic log_lock [128];
  logic log_fill [128];
  int stab_err = 0, lockrel_err = 0, ready_in_fill = 0;
  int tlb_seen = 0, fault_seen = 0;
  logic [19:0] cap_vpn, cap_pfn;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_lookup(input logic [31:0] a);
    if (a == m_addr[0]) return m_data[0];
    if (a == m_addr[1]) return m_data[1];
    return 32'hFEED_0000;
  endfunction

  // Bus memory model: one wait cycle after each strobe, BEATS beats on fills
  initial begin
    logic [31:0] a, d;
    logic w, l, f;
    int nb;
    bus_brdy_i  = 1'b0;
    bus_rdata_i = '0;
    @(negedge clk);
    forever begin
      if (bus_ads_o && rst_n) begin
        a = bus_addr_o; w = bus_wr_o; l = bus_lock_o; f = bus_fill_o; d = bus_wdata_o;
        if (n_log < 128) begin
          log_addr[n_log] = a; log_wr[n_log] = w; log_lock[n_log] = l; log_fill[n_log] = f;
        end
        n_log++;
        @(negedge clk);
        if (bus_addr_o !== a || bus_wr_o !== w || bus_lock_o !== l) stab_err++;
        nb = f ? BEATS : 1;
        for (int b = 0; b < nb; b++) begin
          bus_brdy_i  = 1'b1;
          bus_rdata_i = rd_lookup(a);
          if (w) begin
            if (a == m_addr[0]) m_data[0] = d;
            else if (a == m_addr[1]) m_data[1] = d;
          end
          @(negedge clk);
          if (f && (b < nb - 1) && miss_ready_o) ready_in_fill++;
        end
        bus_brdy_i = 1'b0;
        if (w && bus_lock_o) lockrel_err++;
      end else begin
        @(negedge clk);
      end
    end
  end

  always @(negedge clk) begin
    if (tlb_load_o) begin
      tlb_seen++;
      cap_vpn = tlb_vpn_o;
      cap_pfn = tlb_pfn_o;
    end
    if (walk_fault_o) fault_seen++;
  end

  task automatic run_walk(input logic [31:0] lin, input logic wr);
    int guard = 0;
    while (!miss_ready_o) @(negedge clk);
    miss_valid_i = 1'b1; miss_lin_i = lin; miss_write_i = wr;
    @(negedge clk);
    miss_valid_i = 1'b0;
    while (!miss_ready_o && guard < 500) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [31:0] pde_a, pte_a;
  int l0, tb0, f0, s0, k0, r0, n, pidx, last;
  bit ok;

  initial begin
    vec_t t;
    rst_n = 1'b0; miss_valid_i = 1'b0; miss_lin_i = '0; miss_write_i = 1'b0;
    dir_base_i = BASE;
    m_addr[0] = '1; m_addr[1] = '1; m_data[0] = '0; m_data[1] = '0;
    repeat (3) @(negedge clk);
    chk(miss_ready_o && !bus_ads_o && !bus_lock_o && !tlb_load_o && !walk_fault_o,
        "R1", "reset state", {27'd0, miss_ready_o, bus_ads_o, bus_lock_o, tlb_load_o, walk_fault_o},
        32'h10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      t = VEC[v];
      pde_a = BASE + {20'd0, t.lin[31:22], 2'b00};
      pte_a = {t.pde[31:12], 12'h000} + {20'd0, t.lin[21:12], 2'b00};
      m_addr[0] = pde_a; m_data[0] = t.pde;
      m_addr[1] = pte_a; m_data[1] = t.pte;
      l0 = n_log; tb0 = tlb_seen; f0 = fault_seen; s0 = stab_err; k0 = lockrel_err; r0 = ready_in_fill;
      run_walk(t.lin, t.wr);
      repeat (2) @(negedge clk);
      n = n_log - l0;
      chk(n == int'(t.ncyc), "R4", "bus cycle count", n, t.ncyc);
      chk(log_addr[l0] == pde_a && !log_lock[l0] && !log_wr[l0], "R2", "directory read",
          log_addr[l0], pde_a);
      chk((fault_seen - f0) == (t.flt ? 1 : 0), "R8", "fault pulses", fault_seen - f0, t.flt);
      chk(m_data[0] == t.pde_f, "R7", "directory entry in memory", m_data[0], t.pde_f);
      chk(m_data[1] == t.pte_f, "R7", "table entry in memory", m_data[1], t.pte_f);
      ok = 1'b1;
      for (int i = l0; i < n_log; i++) begin
        if (log_wr[i])
          ok &= log_lock[i] && i > l0 && log_lock[i-1] && !log_wr[i-1] && log_addr[i-1] == log_addr[i];
        else if (log_lock[i])
          ok &= i > l0 && !log_lock[i-1] && log_addr[i-1] == log_addr[i];
      end
      chk(ok, "R5", "locked pair order", ok, 1);
      chk(stab_err == s0, "R11", "held during cycle", stab_err - s0, 0);
      chk(lockrel_err == k0, "R6", "lock release", lockrel_err - k0, 0);
      if (t.pde[0]) begin
        pidx = l0 + (t.pde[5] ? 1 : 3);
        chk(log_addr[pidx] == pte_a && !log_lock[pidx], "R3", "table read", log_addr[pidx], pte_a);
      end
      if (t.flt) begin
        chk(tlb_seen == tb0, "R8", "no TLB load on fault", tlb_seen - tb0, 0);
      end else begin
        last = n_log - 1;
        chk(tlb_seen - tb0 == 1 && cap_vpn == t.lin[31:12] && cap_pfn == t.pte_f[31:12],
            "R9", "TLB load", {cap_vpn, 12'd0}, {t.lin[31:12], 12'd0});
        chk(log_fill[last] && log_addr[last] == {t.pte_f[31:12], t.lin[11:0]},
            "R10", "fill address", log_addr[last], {t.pte_f[31:12], t.lin[11:0]});
        chk(ready_in_fill == r0, "R10", "busy through all beats", ready_in_fill - r0, 0);
      end
    end

    // R1: request held while busy is ignored
    t = VEC[1];
    pde_a = BASE + {20'd0, t.lin[31:22], 2'b00};
    pte_a = {t.pde[31:12], 12'h000} + {20'd0, t.lin[21:12], 2'b00};
    m_addr[0] = pde_a; m_data[0] = t.pde;
    m_addr[1] = pte_a; m_data[1] = t.pte;
    l0 = n_log; tb0 = tlb_seen;
    miss_valid_i = 1'b1; miss_lin_i = t.lin; miss_write_i = 1'b0;
    @(negedge clk);
    miss_lin_i = 32'h5555_5555; miss_write_i = 1'b1;
    ok = 1'b1;
    repeat (3) begin
      @(negedge clk);
      ok &= !miss_ready_o;
    end
    miss_valid_i = 1'b0;
    chk(ok, "R1", "not ready while busy", ok, 1);
    while (!miss_ready_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_log - l0 == 7, "R1", "single walk only", n_log - l0, 7);
    chk(tlb_seen - tb0 == 1 && cap_vpn == t.lin[31:12], "R1", "first request kept",
        {cap_vpn, 12'd0}, {t.lin[31:12], 12'd0});
    chk(m_data[1] == 32'h0045_6021, "R7", "read access leaves dirty clear", m_data[1], 32'h0045_6021);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule